// File: doc/BRIEF.md
# Redundant Scan Stepper Driver

This block commands a four-winding scan stepper motor through two independent drive paths, primary and secondary. The path in use drives a one-hot full-step phase pattern onto its four outputs. The other path keeps all four of its outputs at 0. A path change fires a timed pulse on one of two latching-relay coil outputs, one coil for each path. All eight phase outputs stay off for the length of that pulse.

Single steps come in as a one-cycle request with a direction bit. A seek command steps the motor on its own until a chosen reference indicator reads 1. The reference is either the start-of-scan input or the nadir input. The seek gives up after a programmable number of steps and then raises a timeout flag. The position inputs are taken to be synchronous to `clk` already. `PULSE_CYCLES` sets the coil pulse length in clock cycles; its default is half a second at 100 MHz. `STEP_GAP` sets the number of cycles between steps during a seek.

Top module: `scan_step_driver`

## Requirements
- R1: After reset the primary path is active (`active_path`=0), `pri_phase`=1000, `sec_phase`=0000, both coil outputs are 0, and `seek_busy` and `seek_timeout` are 0.
- R2: An accepted `step_req` moves the pattern one place, and the new pattern shows on the outputs in the cycle after the request. With `step_dir`=1 the order is 1000, 0100, 0010, 0001, then 1000 again. With `step_dir`=0 the order runs the other way.
- R3: Only the active path's outputs carry the pattern (`active_path` 0 = primary, 1 = secondary). The inactive path's four outputs are always 0000.
- R4: An accepted `sel_req` raises the coil for `sel_path` (0 = primary coil, 1 = secondary coil) from the next cycle. The coil stays high for exactly `PULSE_CYCLES` cycles. `active_path` takes the new value at the start of the pulse. The pattern position is kept across the change.
- R5: The two coil outputs are never 1 together. A `sel_req` that arrives while a pulse is in progress is ignored: the pulse is not lengthened and the path does not change.
- R6: While either coil is high, all eight phase outputs are 0. A `step_req` in that time is ignored, so the pattern after the pulse is the one from before it.
- R7: A `seek_req` with `seek_tgt`=0 (start indicator) or 1 (nadir indicator) starts a seek in direction `step_dir`. The first step comes in the cycle after the request. Further steps follow every `STEP_GAP` cycles. The seek ends, with `seek_timeout`=0, at the first check after the target indicator reads 1.
- R8: If the target indicator is still 0 after `seek_limit` steps, the seek ends with `seek_timeout`=1. Exactly `seek_limit` steps are taken. The flag stays set until the next accepted `seek_req`.
- R9: While `seek_busy` is 1, `step_req`, `sel_req` and `seek_req` are ignored. When idle, `sel_req` wins over a `seek_req` or `step_req` that arrives in the same cycle.
- R10: A seek whose target already reads 1 ends at its first check. It takes no step and clears `seek_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | One-cycle single-step request |
| step_dir | input | 1 | 1 = forward order, 0 = reverse; also sets the seek direction |
| sel_req | input | 1 | One-cycle path change request |
| sel_path | input | 1 | Path to select: 0 primary, 1 secondary |
| seek_req | input | 1 | One-cycle seek start request |
| seek_tgt | input | 1 | Seek target: 0 start indicator, 1 nadir indicator |
| seek_limit | input | LIMIT_W | Maximum number of steps a seek may take |
| start_pos | input | 1 | High when the motor is at start of scan |
| nadir_pos | input | 1 | High when the motor is at nadir |
| pri_phase | output | 4 | Primary path winding drive, 1 = energised |
| sec_phase | output | 4 | Secondary path winding drive, 1 = energised |
| pri_sel_coil | output | 1 | Primary-position relay coil pulse |
| sec_sel_coil | output | 1 | Secondary-position relay coil pulse |
| active_path | output | 1 | Path currently selected |
| seek_busy | output | 1 | A seek is running |
| seek_timeout | output | 1 | Last seek ran out of steps |

## Verification
Every cycle, the assertions check the following:
- The two coils are never high together.
- All phases are off while a coil is high.
- The inactive path stays dark.
- The active pattern is one-hot and only ever rotates by one place.
- Each coil pulse lasts exactly `PULSE_CYCLES` cycles.
- A timeout appears only at the end of a running seek.

Some behaviour only the bench scenarios can show:
- The absolute step order in each direction.
- That rejected commands leave the pattern and path unchanged.
- The spacing and count of seek steps against the indicator timing.
- The end of a seek when the target is already reached.
- Priority between commands that arrive together.

// File: rtl/scan_step_driver.sv
module scan_step_driver #(
  parameter int PULSE_CYCLES = 50_000_000,
  parameter int STEP_GAP     = 1000,
  parameter int LIMIT_W      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_req,
  input  logic               step_dir,
  input  logic               sel_req,
  input  logic               sel_path,
  input  logic               seek_req,
  input  logic               seek_tgt,
  input  logic [LIMIT_W-1:0] seek_limit,
  input  logic               start_pos,
  input  logic               nadir_pos,
  output logic [3:0]         pri_phase,
  output logic [3:0]         sec_phase,
  output logic               pri_sel_coil,
  output logic               sec_sel_coil,
  output logic               active_path,
  output logic               seek_busy,
  output logic               seek_timeout
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int GW = $clog2(STEP_GAP + 1);

  logic [1:0]         idx;
  logic [PW-1:0]      pcnt;
  logic               tgt, sdir;
  logic [LIMIT_W-1:0] rem;
  logic [GW-1:0]      gap;

  wire pulsing   = pri_sel_coil | sec_sel_coil;
  wire hit       = tgt ? nadir_pos : start_pos;
  wire eval      = seek_busy && (gap == '0);
  wire seek_step = eval && !hit && (rem != '0);
  wire idle      = !pulsing && !seek_busy;
  wire sel_go    = sel_req && idle;
  wire seek_go   = seek_req && idle && !sel_req;
  wire man_step  = step_req && idle && !sel_req && !seek_req;
  wire do_step   = seek_step | man_step;
  wire dir       = seek_busy ? sdir : step_dir;
  wire [3:0] pat = 4'b1000 >> idx;

  assign pri_phase = (!pulsing && !active_path) ? pat : 4'b0000;
  assign sec_phase = (!pulsing &&  active_path) ? pat : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= 2'd0;
    else if (do_step) idx <= dir ? idx + 2'd1 : idx - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_sel_coil <= 1'b0;
      sec_sel_coil <= 1'b0;
      active_path  <= 1'b0;
      pcnt         <= '0;
    end else if (sel_go) begin
      pri_sel_coil <= !sel_path;
      sec_sel_coil <= sel_path;
      active_path  <= sel_path;
      pcnt         <= PW'(PULSE_CYCLES - 1);
    end else if (pulsing) begin
      if (pcnt == '0) begin
        pri_sel_coil <= 1'b0;
        sec_sel_coil <= 1'b0;
      end else begin
        pcnt <= pcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seek_busy    <= 1'b0;
      seek_timeout <= 1'b0;
      tgt          <= 1'b0;
      sdir         <= 1'b0;
      rem          <= '0;
      gap          <= '0;
    end else if (seek_go) begin
      seek_busy    <= 1'b1;
      seek_timeout <= 1'b0;
      tgt          <= seek_tgt;
      sdir         <= step_dir;
      rem          <= seek_limit;
      gap          <= '0;
    end else if (eval) begin
      if (hit) begin
        seek_busy <= 1'b0;
      end else if (rem == '0) begin
        seek_busy    <= 1'b0;
        seek_timeout <= 1'b1;
      end else begin
        rem <= rem - 1'b1;
        gap <= GW'(STEP_GAP - 1);
      end
    end else if (seek_busy) begin
      gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/scan_step_driver_chk.sv
module scan_step_driver_chk #(
  parameter int PULSE_CYCLES = 50_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] pri_phase,
  input logic [3:0] sec_phase,
  input logic       pri_sel_coil,
  input logic       sec_sel_coil,
  input logic       active_path,
  input logic       seek_busy,
  input logic       seek_timeout
);
  logic       pv;
  logic [3:0] prev_act;
  logic       prev_coil, prev_busy, prev_tmo;
  int         hcnt;
  wire  [3:0] act  = pri_phase | sec_phase;
  wire        coil = pri_sel_coil | sec_sel_coil;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= 1'b0; prev_act <= 4'b0; prev_coil <= 1'b0;
      prev_busy <= 1'b0; prev_tmo <= 1'b0; hcnt <= 0;
    end else begin
      pv <= 1'b1; prev_act <= act; prev_coil <= coil;
      prev_busy <= seek_busy; prev_tmo <= seek_timeout;
      hcnt <= coil ? hcnt + 1 : 0;
    end
  end

  a_r5_coils_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_sel_coil && sec_sel_coil));
  a_r6_dark_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    coil |-> (act == 4'b0000));
  a_r3_inactive_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (active_path ? pri_phase : sec_phase) == 4'b0000);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !coil |-> ($countones(act) == 1));
  a_r2_rotate_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && act != 4'b0 && prev_act != 4'b0 && act != prev_act) |->
      (act == {prev_act[0], prev_act[3:1]} || act == {prev_act[2:0], prev_act[3]}));
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && prev_coil && !coil) |-> (hcnt == PULSE_CYCLES));
  a_r8_timeout_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && seek_timeout && !prev_tmo) |-> (prev_busy && !seek_busy));
endmodule

bind scan_step_driver scan_step_driver_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pri_phase(pri_phase), .sec_phase(sec_phase),
  .pri_sel_coil(pri_sel_coil), .sec_sel_coil(sec_sel_coil),
  .active_path(active_path), .seek_busy(seek_busy), .seek_timeout(seek_timeout)
);

// File: tb/scan_step_driver_bench.sv
module scan_step_driver_bench;
  localparam int PC = 20, GAP = 3, LW = 6;

  logic clk = 0, rst_n = 0;
  logic step_req = 0, step_dir = 1, sel_req = 0, sel_path = 0;
  logic seek_req = 0, seek_tgt = 0, start_pos = 0, nadir_pos = 0;
  logic [LW-1:0] seek_limit = '0;
  logic [3:0] pri_phase, sec_phase;
  logic pri_sel_coil, sec_sel_coil, active_path, seek_busy, seek_timeout;

  int checks = 0, fails = 0;
  int m_idx = 0;
  logic m_path = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scan_step_driver #(.PULSE_CYCLES(PC), .STEP_GAP(GAP), .LIMIT_W(LW)) u_scan_step_driver (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_dir(step_dir),
    .sel_req(sel_req), .sel_path(sel_path), .seek_req(seek_req), .seek_tgt(seek_tgt),
    .seek_limit(seek_limit), .start_pos(start_pos), .nadir_pos(nadir_pos),
    .pri_phase(pri_phase), .sec_phase(sec_phase), .pri_sel_coil(pri_sel_coil),
    .sec_sel_coil(sec_sel_coil), .active_path(active_path), .seek_busy(seek_busy),
    .seek_timeout(seek_timeout));

  function automatic logic [3:0] pat(int i);
    return 4'b1000 >> (i & 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_phases(string tag);
    chk({tag, " pri"}, pri_phase, m_path ? 4'b0 : pat(m_idx));
    chk({tag, " sec"}, sec_phase, m_path ? pat(m_idx) : 4'b0);
  endtask

  task automatic do_step(logic d);
    step_dir = d; step_req = 1;
    @(negedge clk); step_req = 0;
    m_idx = d ? m_idx + 1 : m_idx + 3;
  endtask

  task automatic t_reset;
    chk("R1 path", active_path, 0);
    chk("R1 pri", pri_phase, 4'b1000);
    chk("R1 sec", sec_phase, 4'b0000);
    chk("R1 coils", {pri_sel_coil, sec_sel_coil}, 0);
    chk("R1 seek", {seek_busy, seek_timeout}, 0);
  endtask

  task automatic t_step_order;
    for (int i = 0; i < 5; i++) begin do_step(1); chk_phases("R2 fwd"); end
    for (int i = 0; i < 6; i++) begin do_step(0); chk_phases("R2 rev"); end
  endtask

  task automatic t_select(logic p);
    int hi = 0;
    sel_path = p; sel_req = 1;
    @(negedge clk); sel_req = 0;
    m_path = p;
    chk("R4 path", active_path, p);
    chk("R6 dark", {pri_phase, sec_phase}, 0);
    while (pri_sel_coil | sec_sel_coil) begin
      chk("R5 excl", pri_sel_coil & sec_sel_coil, 0);
      chk("R4 coil", p ? sec_sel_coil : pri_sel_coil, 1);
      if (hi == 3) begin step_req = 1; step_dir = 1; end
      if (hi == 5) begin sel_req = 1; sel_path = !p; end
      hi++;
      @(negedge clk); step_req = 0; sel_req = 0;
    end
    chk("R4 width", hi, PC);
    chk("R5 path kept", active_path, p);
    chk_phases("R3/R6 after pulse");
  endtask

  task automatic seek_run(logic t, logic d, int lim, int hit_after,
                          output int steps);
    logic [3:0] last;
    int cyc = 0, gapc = -1;
    steps = 0;
    seek_tgt = t; step_dir = d; seek_limit = LW'(lim); seek_req = 1;
    last = pri_phase | sec_phase;
    @(negedge clk); seek_req = 0;
    while (seek_busy && cyc < 500) begin
      if ((pri_phase | sec_phase) != last) begin
        if (gapc >= 0) chk("R7 gap", gapc, GAP);
        gapc = 0;
        steps++; m_idx = d ? m_idx + 1 : m_idx + 3;
        last = pri_phase | sec_phase;
        if (steps == hit_after) begin
          if (t) nadir_pos = 1; else start_pos = 1;
        end
        step_req = 1; sel_req = 1; sel_path = !m_path; seek_req = 1; step_dir = !d;
      end else begin
        step_req = 0; sel_req = 0; seek_req = 0;
      end
      if (gapc >= 0) gapc++;
      cyc++;
      @(negedge clk);
    end
    step_req = 0; sel_req = 0; seek_req = 0;
    if ((pri_phase | sec_phase) != last) begin steps++; m_idx = d ? m_idx + 1 : m_idx + 3; end
    chk("R9 no coil", {pri_sel_coil, sec_sel_coil}, 0);
    chk("R9 path", active_path, m_path);
  endtask

  task automatic t_seek_found;
    int s;
    seek_run(0, 1, 20, 4, s);
    chk("R7 start steps", s, 4);
    chk("R7 no tmo", seek_timeout, 0);
    chk_phases("R7 start pos");
    start_pos = 0;
    seek_run(1, 0, 20, 2, s);
    chk("R7 nadir steps", s, 2);
    chk_phases("R7 nadir pos");
    nadir_pos = 0;
  endtask

  task automatic t_seek_timeout;
    int s;
    seek_run(1, 1, 5, 99, s);
    chk("R8 steps", s, 5);
    chk("R8 tmo", seek_timeout, 1);
    chk_phases("R8 pos");
    do_step(1);
    chk("R8 tmo held", seek_timeout, 1);
    chk_phases("R8 step after");
  endtask

  task automatic t_seek_already;
    int s;
    start_pos = 1;
    seek_run(0, 1, 7, 99, s);
    chk("R10 steps", s, 0);
    chk("R10 tmo cleared", seek_timeout, 0);
    chk_phases("R10 pos");
    start_pos = 0;
  endtask

  task automatic t_priority;
    sel_path = !m_path; sel_req = 1; seek_req = 1; step_req = 1; seek_tgt = 0; seek_limit = 3;
    @(negedge clk); sel_req = 0; seek_req = 0; step_req = 0;
    m_path = !m_path;
    chk("R9 prio busy", seek_busy, 0);
    chk("R9 prio coil", pri_sel_coil | sec_sel_coil, 1);
    repeat (PC) @(negedge clk);
    chk_phases("R9 prio no step");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_step_order;
    t_select(1);
    do_step(1); chk_phases("R3 secondary step");
    t_select(0);
    t_seek_found;
    t_seek_timeout;
    t_seek_already;
    t_priority;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule